// File: doc/BRIEF.md
# AHCI Interrupt Front-End Gate

This block sits between the interrupt requests of a two-port AHCI SATA host and the system interrupt controller. The AHCI side presents each port's request only after the port's own interrupt enable has qualified it. This block adds a second enable stage. Each rising edge of a request latches a sticky flag at a fixed bit of a 32-bit flag register. A 32-bit mask register selects which flags may drive the single level-sensitive system interrupt line. A port event therefore reaches the system only when both enable stages pass it.

Software reads both registers through a small word-addressed 32-bit register bus. It clears flags by writing ones. The bus carries data in big-endian byte order. A second output carries debug interrupt events straight through, one cycle late. The flags and the mask never affect it.

Top module: `ahci_irq_gate`

## Requirements
- R1: After reset the flag register and the mask register both read zero, and `irq_o` and `dbg_irq_o` are low.
- R2: A 0-to-1 transition seen on `media_evt_i`, `port0_irq_i` or `port1_irq_i` sets flag bit 0, bit 3 or bit 5 respectively, on the clock edge where the high level is first sampled. Every other flag bit always reads zero, and a flag never sets without such a transition.
- R3: A write to the flag register (word address 0) clears every flag whose bit in the written value is 1. Flags whose written bit is 0 keep their value.
- R4: If a flag is cleared by a write in the same cycle that its source shows a rising edge, the flag ends up set.
- R5: A request held high after its flag was cleared does not set the flag again. Only a new low-to-high transition does.
- R6: A write to the mask register (word address 1) replaces all 32 mask bits. The mask changes on no other cycle, and a read returns its current contents.
- R7: `irq_o` is a register. It is high in a cycle exactly when (flag AND mask) was non-zero in the previous cycle.
- R8: Registers appear on the bus big-endian. Bus byte lane k (bits 8k+7..8k) holds the byte at address offset k. So register bits 7..0 sit in bus bits 31..24, and register bits 31..24 sit in bus bits 7..0, in both directions.
- R9: Word addresses 2 and 3 read as zero and ignore writes. With `bus_sel_i` low, `bus_rdata_o` is zero and nothing is written.
- R10: `dbg_irq_o` equals `dbg_evt_i` delayed by one clock, whatever the flags and the mask hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| media_evt_i | input | 1 | Media insertion event request |
| port0_irq_i | input | 1 | Enabled interrupt request from AHCI port 0 |
| port1_irq_i | input | 1 | Enabled interrupt request from AHCI port 1 |
| dbg_evt_i | input | 1 | Debug interrupt event |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_waddr_i | input | WADDR_W | Word address of the register |
| bus_wdata_i | input | 32 | Write data, big-endian lanes |
| bus_rdata_o | output | 32 | Read data, big-endian lanes, combinational |
| irq_o | output | 1 | Masked combined system interrupt, registered |
| dbg_irq_o | output | 1 | Debug interrupt, registered |

## Verification
Assertions check several rules on every cycle:
- A set always wins over a clear.
- A cleared flag stays low.
- Unwritten flags never drop and flags never appear without an edge.
- The mask is stable outside writes.
- The line stays quiet when nothing is pending.
- No source yields two edges in a row.
- The debug line tracks its input with a one-cycle delay.

Only the bench scenarios can show the bit positions each source reaches and the byte-lane order on the bus. The same holds for the behaviour of unused addresses and the re-arming of a held request after a clear. The bench compares every read and every output cycle against its own register model.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

    localparam int unsigned REG_W   = 32;
    localparam int unsigned REG_BYT = REG_W / 8;
    localparam int unsigned NUM_SRC = 3;

    // Reverse byte lanes: bus lane k carries the byte at address offset k,
    // register is big-endian, so register byte 0 (LSB) lands in the top lane.
    function automatic logic [REG_W-1:0] lane_swap(input logic [REG_W-1:0] v);
        logic [REG_W-1:0] r;
        for (int i = 0; i < REG_BYT; i++) begin
            r[8*i +: 8] = v[8*(REG_BYT-1-i) +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_edge_capture.sv
module irq_edge_capture #(
    parameter int unsigned N = 3
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] req_i,
    output logic [N-1:0] rise_o
);

    typedef struct packed {
        logic [N-1:0] prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = req_i;
        rise_o    = req_i & ~st_q.prev;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    AST_NO_BACK_TO_BACK_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> ((rise_o & $past(rise_o)) == '0)); // R5

endmodule

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
    import irq_gate_pkg::*;
#(
    parameter int unsigned WADDR_W = 2
) (
    input  logic               sel_i,
    input  logic               wr_i,
    input  logic [WADDR_W-1:0] waddr_i,
    input  logic [REG_W-1:0]   wdata_i,
    input  logic [REG_W-1:0]   flag_i,
    input  logic [REG_W-1:0]   mask_i,
    output logic [REG_W-1:0]   clr_o,
    output logic               mask_we_o,
    output logic [REG_W-1:0]   mask_wd_o,
    output logic [REG_W-1:0]   rdata_o
);

    localparam logic [WADDR_W-1:0] WA_FLAG = WADDR_W'(0);
    localparam logic [WADDR_W-1:0] WA_MASK = WADDR_W'(1);

    logic [REG_W-1:0] wval;

    always_comb begin
        wval      = lane_swap(wdata_i);
        clr_o     = '0;
        mask_we_o = 1'b0;
        mask_wd_o = wval;
        rdata_o   = '0;
        if (sel_i && wr_i) begin
            if (waddr_i == WA_FLAG) clr_o     = wval;
            if (waddr_i == WA_MASK) mask_we_o = 1'b1;
        end
        if (sel_i && !wr_i) begin
            if (waddr_i == WA_FLAG) rdata_o = lane_swap(flag_i);
            if (waddr_i == WA_MASK) rdata_o = lane_swap(mask_i);
        end
    end

endmodule

// File: rtl/irq_reg_file.sv
module irq_reg_file
    import irq_gate_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [REG_W-1:0] set_i,
    input  logic [REG_W-1:0] clr_i,
    input  logic             mask_we_i,
    input  logic [REG_W-1:0] mask_wd_i,
    output logic [REG_W-1:0] flag_o,
    output logic [REG_W-1:0] mask_o,
    output logic             irq_o
);

    typedef struct packed {
        logic [REG_W-1:0] flag;
        logic [REG_W-1:0] mask;
        logic             irq;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        // set has priority over write-one-to-clear
        r_d.flag = (r_q.flag & ~clr_i) | set_i;
        if (mask_we_i) r_d.mask = mask_wd_i;
        r_d.irq  = |(r_q.flag & r_q.mask);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign flag_o = r_q.flag;
    assign mask_o = r_q.mask;
    assign irq_o  = r_q.irq;

    AST_FLAG_NEEDS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> ((r_q.flag & ~$past(r_q.flag) & ~$past(set_i)) == '0)); // R2
    AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(clr_i & ~set_i)) |=> ((r_q.flag & $past(clr_i & ~set_i)) == '0)); // R3
    AST_UNCLEARED_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> (($past(r_q.flag) & ~$past(clr_i) & ~r_q.flag) == '0)); // R3
    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_i != '0) |=> ((r_q.flag & $past(set_i)) == $past(set_i))); // R4
    AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mask_we_i |=> $stable(r_q.mask)); // R6
    AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && ((r_q.flag & r_q.mask) == '0) && ($past(r_q.flag & r_q.mask) == '0))
        |-> !r_q.irq); // R7

endmodule

// File: rtl/ahci_irq_gate.sv
module ahci_irq_gate
    import irq_gate_pkg::*;
#(
    parameter int unsigned WADDR_W   = 2,
    parameter int unsigned MEDIA_BIT = 0,
    parameter int unsigned PORT0_BIT = 3,
    parameter int unsigned PORT1_BIT = 5
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               media_evt_i,
    input  logic               port0_irq_i,
    input  logic               port1_irq_i,
    input  logic               dbg_evt_i,
    input  logic               bus_sel_i,
    input  logic               bus_wr_i,
    input  logic [WADDR_W-1:0] bus_waddr_i,
    input  logic [REG_W-1:0]   bus_wdata_i,
    output logic [REG_W-1:0]   bus_rdata_o,
    output logic               irq_o,
    output logic               dbg_irq_o
);

    localparam int unsigned SRC_POS [NUM_SRC] = '{MEDIA_BIT, PORT0_BIT, PORT1_BIT};

    logic [NUM_SRC-1:0] req, rise;
    logic [REG_W-1:0]   set_vec, clr_vec, mask_wd, flag_q, mask_q;
    logic               mask_we;
    logic               dbg_d, dbg_q;

    assign req = {port1_irq_i, port0_irq_i, media_evt_i};

    irq_edge_capture #(.N(NUM_SRC)) u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .req_i  (req),
        .rise_o (rise)
    );

    always_comb begin
        set_vec = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            set_vec[SRC_POS[s]] = set_vec[SRC_POS[s]] | rise[s];
        end
    end

    irq_bus_decode #(.WADDR_W(WADDR_W)) u_dec (
        .sel_i     (bus_sel_i),
        .wr_i      (bus_wr_i),
        .waddr_i   (bus_waddr_i),
        .wdata_i   (bus_wdata_i),
        .flag_i    (flag_q),
        .mask_i    (mask_q),
        .clr_o     (clr_vec),
        .mask_we_o (mask_we),
        .mask_wd_o (mask_wd),
        .rdata_o   (bus_rdata_o)
    );

    irq_reg_file u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .set_i     (set_vec),
        .clr_i     (clr_vec),
        .mask_we_i (mask_we),
        .mask_wd_i (mask_wd),
        .flag_o    (flag_q),
        .mask_o    (mask_q),
        .irq_o     (irq_o)
    );

    // debug line: straight registered pass-through, not gated
    always_comb dbg_d = dbg_evt_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) dbg_q <= 1'b0;
        else         dbg_q <= dbg_d;
    end

    assign dbg_irq_o = dbg_q;

    AST_DBG_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> (dbg_irq_o == $past(dbg_evt_i))); // R10
    AST_SRC_REACHES_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        port0_irq_i && !$past(port0_irq_i) && $past(rst_ni) |=> flag_q[PORT0_BIT]); // R2

endmodule

// File: tb/tb_ahci_irq_gate.sv
`timescale 1ns/1ps
module tb_ahci_irq_gate;
    import irq_gate_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_in = 0, p0_in = 0, p1_in = 0, dbg_in = 0;
    logic        sel = 0, wr = 0;
    logic [1:0]  wa = '0;
    logic [31:0] wd = '0;
    logic [31:0] rdata;
    logic        irq, dbg_irq;

    int total = 0, bad = 0;
    bit done = 0;

    // bench model
    logic [2:0]  m_prev = '0;
    logic [31:0] m_flag = '0, m_mask = '0;
    logic        m_irq = 0, m_dbg = 0;

    always #2.5 clk = ~clk;

    ahci_irq_gate dut (
        .clk_i(clk), .rst_ni(rst_n),
        .media_evt_i(m_in), .port0_irq_i(p0_in), .port1_irq_i(p1_in),
        .dbg_evt_i(dbg_in),
        .bus_sel_i(sel), .bus_wr_i(wr), .bus_waddr_i(wa), .bus_wdata_i(wd),
        .bus_rdata_o(rdata), .irq_o(irq), .dbg_irq_o(dbg_irq)
    );

    function automatic logic [31:0] bswap(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    function automatic logic [31:0] exp_read(input logic s, input logic w, input logic [1:0] a);
        if (!s || w) return '0;
        if (a == 2'd0) return bswap(m_flag);
        if (a == 2'd1) return bswap(m_mask);
        return '0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock: drive after negedge, check read, advance model, check outputs
    task automatic cyc(input logic im, input logic ip0, input logic ip1, input logic idbg,
                       input logic is, input logic iw, input logic [1:0] ia,
                       input logic [31:0] idat, input string tag);
        logic [2:0]  rise;
        logic [31:0] setv, clrv, nflag, nmask;
        logic        nirq;
        @(negedge clk);
        m_in = im; p0_in = ip0; p1_in = ip1; dbg_in = idbg;
        sel = is; wr = iw; wa = ia; wd = idat;
        #1;
        if (is && !iw) chk({tag, " read"}, rdata, exp_read(is, iw, ia));
        if (!is) chk("R9 idle rdata", rdata, '0);
        rise = {ip1, ip0, im} & ~m_prev;
        setv = '0;
        setv[0] = rise[0]; setv[3] = rise[1]; setv[5] = rise[2];
        clrv  = (is && iw && ia == 2'd0) ? bswap(idat) : '0;
        nflag = (m_flag & ~clrv) | setv;
        nmask = (is && iw && ia == 2'd1) ? bswap(idat) : m_mask;
        nirq  = |(m_flag & m_mask);
        @(posedge clk);
        #1;
        m_prev = {ip1, ip0, im}; m_flag = nflag; m_mask = nmask;
        m_irq = nirq; m_dbg = idbg;
        chk("R7 irq_o", {31'd0, irq}, {31'd0, m_irq});
        chk("R10 dbg_irq_o", {31'd0, dbg_irq}, {31'd0, m_dbg});
    endtask

    task automatic rd(input logic [1:0] a, input string tag);
        cyc(m_in, p0_in, p1_in, 1'b0, 1'b1, 1'b0, a, '0, tag);
    endtask

    task automatic wrt(input logic [1:0] a, input logic [31:0] d, input string tag);
        cyc(m_in, p0_in, p1_in, 1'b0, 1'b1, 1'b1, a, d, tag);
    endtask

    task automatic src(input logic im, input logic ip0, input logic ip1, input string tag);
        cyc(im, ip0, ip1, 1'b0, 1'b0, 1'b0, 2'd0, '0, tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A7A));
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);
        chk("R1 dbg after reset", {31'd0, dbg_irq}, 32'd0);
        rd(2'd0, "R1 flag reset");
        rd(2'd1, "R1 mask reset");

        // R2 port0 edge sets bit 3 (bus view 0x08000000)
        src(0, 1, 0, "R2 port0 rise");
        rd(2'd0, "R2 flag bit3");
        chk("R2 R8 flag lane", rdata, 32'h0800_0000);
        src(1, 1, 1, "R2 media+port1 rise");
        rd(2'd0, "R2 flags 0,3,5");
        chk("R2 flags 0,3,5 lanes", rdata, 32'h2900_0000);

        // R8 R6 mask write: bus 0x000000FF -> register 0xFF000000, irq stays low
        wrt(2'd1, 32'h0000_00FF, "R6 mask write");
        rd(2'd1, "R6 R8 mask read");
        chk("R8 mask lanes", rdata, 32'h0000_00FF);
        src(1, 1, 1, "R7 no overlap");
        // R7 enable bit 3 -> irq next cycle after mask lands
        wrt(2'd1, 32'h0800_0000, "R6 mask bit3");
        src(1, 1, 1, "R7 irq rises");
        chk("R7 irq high", {31'd0, irq}, 32'd1);

        // R3 writing zeros keeps flags
        wrt(2'd0, 32'h0000_0000, "R3 zero write");
        rd(2'd0, "R3 flags kept");
        // R5 clear bit 3 while port0 held high: stays clear
        wrt(2'd0, 32'h0800_0000, "R3 clear bit3");
        src(1, 1, 1, "R5 held");
        src(1, 1, 1, "R5 held 2");
        rd(2'd0, "R5 bit3 stays clear");
        chk("R5 irq low", {31'd0, irq}, 32'd0);

        // R4 drop port0, then rise in the same cycle as its clear
        src(1, 0, 1, "R4 drop");
        cyc(1, 1, 1, 0, 1, 1, 2'd0, 32'h0800_0000, "R4 set vs clear");
        rd(2'd0, "R4 set wins");
        chk("R4 bit3 kept", rdata & 32'h0800_0000, 32'h0800_0000);

        // R9 unused addresses
        wrt(2'd2, 32'hFFFF_FFFF, "R9 write addr2");
        wrt(2'd3, 32'hFFFF_FFFF, "R9 write addr3");
        rd(2'd2, "R9 read addr2");
        rd(2'd3, "R9 read addr3");
        rd(2'd1, "R9 mask untouched");
        cyc(1, 1, 1, 0, 0, 1, 2'd1, 32'hFFFF_FFFF, "R9 unselected write");
        rd(2'd1, "R9 mask after unselected write");

        // R10 debug pulse with mask cleared
        wrt(2'd1, 32'h0, "R10 mask off");
        cyc(1, 1, 1, 1, 0, 0, 2'd0, '0, "R10 dbg high");
        cyc(1, 1, 1, 0, 0, 0, 2'd0, '0, "R10 dbg low");

        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r, d;
            r = $urandom;
            d = $urandom;
            if (r[7:5] == 3'd0) d = {d[31:24] & 8'h29, d[23:0]};
            cyc(r[0] ^ m_in & r[8], r[1] ^ p0_in & r[9], r[2] ^ p1_in & r[10], r[3],
                r[4], r[11] & r[12], r[14:13], d, "R2 R3 R6 R7 random");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule